// File: doc/BRIEF.md
# Addend-Tuned Precision Time Counter

This block keeps a 64-bit time-of-day count for a precision time protocol node. On every clock a programmable 32-bit rate word is summed into a 32-bit fraction register; each carry out of that sum advances the time count by one tick, and one tick stands for 32 ns. Software tunes frequency by nudging the rate word, sets and reads time through split low and high words, and gets exact captures of the count from two external trigger lines.

A target-time comparator, a seconds-boundary pulse and the two captures each raise a sticky flag. Each flag can be enabled onto a single interrupt line. A bit in the control word puts the whole time base back into its power-up state for as long as it stays set. Time writes go through a two-state staging machine, TW_IDLE and TW_STAGED. A low-word write takes TW_IDLE to TW_STAGED. A high-word write in TW_STAGED loads both halves and returns to TW_IDLE. A high-word write in TW_IDLE replaces only the high half. Another low-word write in TW_STAGED replaces the staged value.

Word addresses: 0 control, 1 flags, 2 rate word, 3/4 time low/high, 5/6 target low/high, 7/8 trigger-0 capture low/high, 9/10 trigger-1 capture low/high, 11 wrap-limit unlock, 12 wrap limit.

Top module: `ptp_timebase`

## Requirements
- R1: After reset the control word and the flags read 0, the rate word reads 0xA0000000, target high reads 0xFFFFFFFF, the wrap limit reads 0xFFFFFFFE and irq is 0.
- R2: The time count advances once per carry out of the 32-bit fraction sum. With the rate word at 0xA0000000 it advances exactly 500 ticks in any 800 consecutive clocks, and with the rate word at 0 it does not move.
- R3: A low-word write is staged. A following high-word write loads both halves on one clock and clears the fraction register. A high-word write with nothing staged changes only the high half.
- R4: Reading the time low word latches the high word, and a later read of the high word returns that latched value even if time has since been written.
- R5: The low word counts up to the wrap limit, then goes to 0 and carries one into the high word.
- R6: Writing 1 to bit 0 of word 11 unlocks word 12, so that a write there sets the wrap limit. Writes to word 12 while it is locked leave the limit unchanged.
- R7: While control bit 0 is 1, everything except the control word is held in its reset state. Clearing that bit resumes operation from the reset values.
- R8: A rising edge on aux_in[0] copies the time count into words 7/8 and sets flag bit 2. A rising edge on aux_in[1] copies it into words 9/10 and sets flag bit 3. A new edge overwrites a capture even while its flag is still set.
- R9: Flag bit 1 is set on every clock where the time count is greater than or equal to the 64-bit target.
- R10: Flag bit 4 is set each time TICKS_PER_SEC ticks have elapsed since the last time write.
- R11: Flags are cleared by writing 1 to their bit in word 1. Writing 0 leaves them unchanged, and a set condition wins over a clear on the same clock.
- R12: irq is 1 exactly when some flag bit n (1 to 4) is set while control bit n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the clock after bus_rd |
| aux_in | input | 2 | External trigger lines |
| irq | output | 1 | Interrupt request |

## Verification
The counter is exercised under three rate words: the default 0xA0000000, a frozen rate of 0, and 0x80000000 applied for exactly four clocks to inject two ticks. These show, in turn, the long-run ratio, the absence of spurious motion, and exact single-tick steps across the wrap limit. Time is then loaded at values just below the default and the unlocked limit, which separates a wrap at 0xFFFFFFFE from a wrap at all ones. The staged, unstaged and shadowed accesses show whether the halves move together. Trigger edges at two different frozen times show that a capture is overwritten while its flag is still set.

// File: rtl/ptp_tc_pkg.sv
package ptp_tc_pkg;

    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL  = 4'd0,
        A_FLAGS = 4'd1,
        A_RATE  = 4'd2,
        A_TLO   = 4'd3,
        A_THI   = 4'd4,
        A_TGLO  = 4'd5,
        A_TGHI  = 4'd6,
        A_C0LO  = 4'd7,
        A_C0HI  = 4'd8,
        A_C1LO  = 4'd9,
        A_C1HI  = 4'd10,
        A_UNLK  = 4'd11,
        A_LIMIT = 4'd12
    } reg_addr_e;

    localparam int FL_TGT = 1;
    localparam int FL_C0  = 2;
    localparam int FL_C1  = 3;
    localparam int FL_SEC = 4;

    typedef enum logic {
        TW_IDLE,
        TW_STAGED
    } tw_state_e;

endpackage

// File: rtl/ptp_rate_accum.sv
module ptp_rate_accum #(
    parameter int          FRAC_W        = 32,
    parameter int unsigned TICKS_PER_SEC = 31_250_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst,
    input  logic [FRAC_W-1:0] rate,
    input  logic              frac_clr,
    input  logic              time_wr,
    output logic              tick,
    output logic              sec_pulse
);
    localparam int SEC_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(TICKS_PER_SEC - 1);

    logic [FRAC_W-1:0] frac_q;
    logic [FRAC_W:0]   sum;
    logic [SEC_W-1:0]  sec_q;

    assign sum       = {1'b0, frac_q} + {1'b0, rate};
    assign tick      = sum[FRAC_W];
    assign sec_pulse = tick && !time_wr && (sec_q == SEC_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frac_q <= '0;
        end else if (srst || frac_clr) begin
            frac_q <= '0;
        end else begin
            frac_q <= sum[FRAC_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q <= '0;
        end else if (srst || time_wr) begin
            sec_q <= '0;
        end else if (tick) begin
            sec_q <= (sec_q == SEC_LAST) ? '0 : sec_q + 1'b1;
        end
    end
endmodule

// File: rtl/ptp_time_core.sv
module ptp_time_core
    import ptp_tc_pkg::*;
#(
    parameter int          W            = 32,
    parameter logic [31:0] LO_LIMIT_RST = 32'hFFFF_FFFE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         srst,
    input  logic         tick,
    input  logic         wr_lo,
    input  logic         wr_hi,
    input  logic         wr_unlk,
    input  logic         wr_limit,
    input  logic [W-1:0] wdata,
    output logic [2*W-1:0] sys_time,
    output logic [W-1:0] lo_limit,
    output logic         unlocked,
    output logic         time_wr,
    output logic         full_load
);
    tw_state_e    state_q, state_d;
    logic         hi_only;
    logic [W-1:0] stage_q, lo_q, hi_q, lim_q;
    logic         unlk_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TW_IDLE;
        end else if (srst) begin
            state_q <= TW_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and load decodes
    always_comb begin
        state_d   = state_q;
        full_load = 1'b0;
        hi_only   = 1'b0;
        unique case (state_q)
            TW_IDLE: begin
                if (wr_lo) begin
                    state_d = TW_STAGED;
                end else if (wr_hi) begin
                    hi_only = 1'b1;
                end
            end
            TW_STAGED: begin
                if (wr_hi) begin
                    full_load = 1'b1;
                    state_d   = TW_IDLE;
                end
            end
            default: state_d = TW_IDLE;
        endcase
    end

    assign time_wr = full_load || hi_only;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (srst) begin
            stage_q <= '0;
        end else if (wr_lo) begin
            stage_q <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (srst) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (full_load) begin
            lo_q <= stage_q;
            hi_q <= wdata;
        end else if (hi_only) begin
            hi_q <= wdata;
        end else if (tick) begin
            if (lo_q == lim_q) begin
                lo_q <= '0;
                hi_q <= hi_q + 1'b1;
            end else begin
                lo_q <= lo_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            unlk_q <= 1'b0;
            lim_q  <= LO_LIMIT_RST;
        end else if (srst) begin
            unlk_q <= 1'b0;
            lim_q  <= LO_LIMIT_RST;
        end else begin
            if (wr_unlk) unlk_q <= wdata[0];
            if (wr_limit && unlk_q) lim_q <= wdata;
        end
    end

    assign sys_time = {hi_q, lo_q};
    assign lo_limit = lim_q;
    assign unlocked = unlk_q;
endmodule

// File: rtl/ptp_event_unit.sv
module ptp_event_unit
    import ptp_tc_pkg::*;
#(
    parameter int T_W    = 64,
    parameter int N_TRIG = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      srst,
    input  logic [T_W-1:0]            sys_time,
    input  logic [T_W-1:0]            target,
    input  logic [N_TRIG-1:0]         trig_in,
    input  logic                      sec_pulse,
    input  logic                      clr_wr,
    input  logic [4:0]                clr_bits,
    input  logic [4:1]                irq_en,
    output logic [4:0]                flags,
    output logic [N_TRIG-1:0][T_W-1:0] snap,
    output logic                      irq
);
    logic [N_TRIG-1:0] prev_q, cap;
    logic [4:0]        flag_q, set_v, clr_v;

    for (genvar c = 0; c < N_TRIG; c++) begin : g_trig
        assign cap[c] = trig_in[c] && !prev_q[c];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q[c] <= 1'b0;
                snap[c]   <= '0;
            end else if (srst) begin
                prev_q[c] <= 1'b0;
                snap[c]   <= '0;
            end else begin
                prev_q[c] <= trig_in[c];
                if (cap[c]) snap[c] <= sys_time;
            end
        end
    end

    always_comb begin
        set_v         = '0;
        set_v[FL_TGT] = (sys_time >= target);
        set_v[FL_C0]  = cap[0];
        set_v[FL_C1]  = cap[N_TRIG-1];
        set_v[FL_SEC] = sec_pulse;
        clr_v         = clr_wr ? clr_bits : 5'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else if (srst) begin
            flag_q <= '0;
        end else begin
            flag_q <= ((flag_q & ~clr_v) | set_v) & 5'b11110;
        end
    end

    assign flags = flag_q;
    assign irq   = |(flag_q[4:1] & irq_en);
endmodule

// File: rtl/ptp_timebase.sv
module ptp_timebase
    import ptp_tc_pkg::*;
#(
    parameter logic [31:0] RATE_RST      = 32'hA000_0000,
    parameter logic [31:0] LO_LIMIT_RST  = 32'hFFFF_FFFE,
    parameter int unsigned TICKS_PER_SEC = 31_250_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [1:0]  aux_in,
    output logic        irq
);
    localparam int W   = 32;
    localparam int T_W = 2 * W;

    logic [4:0]     ctrl_q;
    logic           srst;
    logic [W-1:0]   rate_q;
    logic [T_W-1:0] target_q;
    logic [T_W-1:0] sys_time;
    logic [W-1:0]   lo_limit;
    logic           unlocked, time_wr, full_load, tick, sec_pulse;
    logic [4:0]     ev_flags;
    logic [1:0][T_W-1:0] snap;
    logic [W-1:0]   shadow_q, rdata_q;
    logic           ev_wr;

    function automatic logic hit(input logic [3:0] a, input reg_addr_e r);
        return a == r;
    endfunction

    assign srst  = ctrl_q[0];
    assign ev_wr = bus_wr && hit(bus_addr, A_FLAGS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (bus_wr && hit(bus_addr, A_CTRL)) begin
            ctrl_q <= bus_wdata[4:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rate_q   <= RATE_RST;
            target_q <= '1;
        end else if (srst) begin
            rate_q   <= RATE_RST;
            target_q <= '1;
        end else if (bus_wr) begin
            if (hit(bus_addr, A_RATE)) rate_q <= bus_wdata;
            if (hit(bus_addr, A_TGLO)) target_q[W-1:0] <= bus_wdata;
            if (hit(bus_addr, A_TGHI)) target_q[T_W-1:W] <= bus_wdata;
        end
    end

    ptp_rate_accum #(.FRAC_W(W), .TICKS_PER_SEC(TICKS_PER_SEC)) u_rate (
        .clk(clk), .rst_n(rst_n), .srst(srst), .rate(rate_q),
        .frac_clr(full_load), .time_wr(time_wr),
        .tick(tick), .sec_pulse(sec_pulse)
    );

    ptp_time_core #(.W(W), .LO_LIMIT_RST(LO_LIMIT_RST)) u_core (
        .clk(clk), .rst_n(rst_n), .srst(srst), .tick(tick),
        .wr_lo(bus_wr && hit(bus_addr, A_TLO)),
        .wr_hi(bus_wr && hit(bus_addr, A_THI)),
        .wr_unlk(bus_wr && hit(bus_addr, A_UNLK)),
        .wr_limit(bus_wr && hit(bus_addr, A_LIMIT)),
        .wdata(bus_wdata), .sys_time(sys_time), .lo_limit(lo_limit),
        .unlocked(unlocked), .time_wr(time_wr), .full_load(full_load)
    );

    ptp_event_unit #(.T_W(T_W), .N_TRIG(2)) u_ev (
        .clk(clk), .rst_n(rst_n), .srst(srst), .sys_time(sys_time),
        .target(target_q), .trig_in(aux_in), .sec_pulse(sec_pulse),
        .clr_wr(ev_wr), .clr_bits(bus_wdata[4:0]), .irq_en(ctrl_q[4:1]),
        .flags(ev_flags), .snap(snap), .irq(irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (srst) begin
            shadow_q <= '0;
        end else if (bus_rd && hit(bus_addr, A_TLO)) begin
            shadow_q <= sys_time[T_W-1:W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            unique case (bus_addr)
                A_CTRL:  rdata_q <= {27'd0, ctrl_q};
                A_FLAGS: rdata_q <= {27'd0, ev_flags};
                A_RATE:  rdata_q <= rate_q;
                A_TLO:   rdata_q <= sys_time[W-1:0];
                A_THI:   rdata_q <= shadow_q;
                A_TGLO:  rdata_q <= target_q[W-1:0];
                A_TGHI:  rdata_q <= target_q[T_W-1:W];
                A_C0LO:  rdata_q <= snap[0][W-1:0];
                A_C0HI:  rdata_q <= snap[0][T_W-1:W];
                A_C1LO:  rdata_q <= snap[1][W-1:0];
                A_C1HI:  rdata_q <= snap[1][T_W-1:W];
                A_UNLK:  rdata_q <= {31'd0, unlocked};
                A_LIMIT: rdata_q <= lo_limit;
                default: rdata_q <= '0;
            endcase
        end
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/ptp_timebase_chk.sv
module ptp_timebase_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        srst,
    input logic        tick,
    input logic        time_wr,
    input logic [63:0] sys_time,
    input logic [31:0] lo_limit,
    input logic [63:0] target_q,
    input logic [31:0] rate_q,
    input logic [4:0]  ev_flags,
    input logic [1:0]  aux_in,
    input logic [63:0] snap0,
    input logic        ev_wr,
    input logic [31:0] bus_wdata,
    input logic        irq
);
    // R2
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n || srst)
        (rate_q == 32'd0 && !time_wr) |=> $stable(sys_time));

    // R5
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n || srst)
        (tick && !time_wr && sys_time[31:0] == lo_limit) |=>
        (sys_time[31:0] == 32'd0 && sys_time[63:32] == $past(sys_time[63:32]) + 32'd1));

    // R9
    target_chk: assert property (@(posedge clk) disable iff (!rst_n || srst)
        (sys_time >= target_q) |=> ev_flags[1]);

    // R8
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n || srst)
        $rose(aux_in[0]) |=> (snap0 == $past(sys_time)));

    // R11
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n || srst)
        (ev_flags[2] && !(ev_wr && bus_wdata[2])) |=> ev_flags[2]);

    // R12
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ev_flags != 5'd0));
endmodule

bind ptp_timebase ptp_timebase_chk u_chk (
    .clk(clk), .rst_n(rst_n), .srst(srst), .tick(tick), .time_wr(time_wr),
    .sys_time(sys_time), .lo_limit(lo_limit), .target_q(target_q),
    .rate_q(rate_q), .ev_flags(ev_flags), .aux_in(aux_in), .snap0(snap[0]),
    .ev_wr(ev_wr), .bus_wdata(bus_wdata), .irq(irq)
);

// File: tb/sim_ptp_timebase.sv
module sim_ptp_timebase;
    import ptp_tc_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  aux_in = '0;
    logic        irq;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    typedef struct {
        string       req;
        logic [31:0] exp;
        logic [31:0] msk;
    } item_t;
    item_t       sb[$];
    logic        rd_d = 1'b0;
    logic [31:0] last_rd = '0;

    always #10 clk = ~clk;

    ptp_timebase #(.TICKS_PER_SEC(4)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .aux_in(aux_in), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops expected items as read data appears
    always @(posedge clk) rd_d <= bus_rd;
    always @(negedge clk) begin
        if (rd_d) begin
            item_t it;
            last_rd = bus_rdata;
            if (sb.size() == 0) begin
                chk("scoreboard-empty", 32'd1, 32'd0);
            end else begin
                it = sb.pop_front();
                if (it.msk != 0) chk(it.req, bus_rdata & it.msk, it.exp & it.msk);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd_m(input string req, input logic [3:0] a,
                        input logic [31:0] e, input logic [31:0] m);
        item_t it;
        it.req = req; it.exp = e; it.msk = m;
        sb.push_back(it);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic rd(input string req, input logic [3:0] a, input logic [31:0] e);
        rd_m(req, a, e, 32'hFFFF_FFFF);
    endtask

    task automatic rd_raw(input logic [3:0] a, output logic [31:0] v);
        item_t it;
        it.req = "raw"; it.exp = '0; it.msk = '0;
        sb.push_back(it);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        @(negedge clk); bus_rd = 1'b0;
        #1 v = last_rd;
    endtask

    task automatic set_time(input logic [31:0] hi, input logic [31:0] lo);
        wr(A_TLO, lo);
        wr(A_THI, hi);
    endtask

    // exactly two ticks, fraction register must be 0 and rate 0 beforehand
    task automatic two_ticks();
        wr(A_RATE, 32'h8000_0000);
        repeat (2) @(negedge clk);
        wr(A_RATE, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] a, b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1 chk("R1 irq after reset", {31'd0, irq}, 32'd0);

        // R1 reset values
        rd("R1 ctrl", A_CTRL, 32'd0);
        rd("R1 flags", A_FLAGS, 32'd0);
        rd("R1 rate", A_RATE, 32'hA000_0000);
        rd("R1 target hi", A_TGHI, 32'hFFFF_FFFF);
        rd("R1 limit", A_LIMIT, 32'hFFFF_FFFE);

        // R2 long-run rate at default rate word: 800 clocks between reads
        rd_raw(A_TLO, a);
        repeat (798) @(negedge clk);
        rd_raw(A_TLO, b);
        chk("R2 ticks in 800 clocks", b - a, 32'd500);
        wr(A_RATE, 32'd0);
        rd_raw(A_TLO, a);
        repeat (50) @(negedge clk);
        rd_raw(A_TLO, b);
        chk("R2 frozen at rate 0", b - a, 32'd0);

        // R3 staged and unstaged writes
        set_time(32'd3, 32'h100);
        rd("R3 load lo", A_TLO, 32'h100);
        rd("R3 load hi", A_THI, 32'd3);
        wr(A_THI, 32'd9);
        rd("R3 hi-only keeps lo", A_TLO, 32'h100);
        rd("R3 hi-only hi", A_THI, 32'd9);
        wr(A_TLO, 32'h55);
        rd("R3 staged lo not applied", A_TLO, 32'h100);
        wr(A_THI, 32'd4);
        rd("R3 atomic lo", A_TLO, 32'h55);
        rd("R3 atomic hi", A_THI, 32'd4);

        // R4 shadow of the high word
        rd("R4 lo read", A_TLO, 32'h55);
        set_time(32'd8, 32'h66);
        rd("R4 shadow keeps old hi", A_THI, 32'd4);
        rd("R4 new lo", A_TLO, 32'h66);
        rd("R4 new hi", A_THI, 32'd8);

        // R5 wrap at default limit, R6 locked limit write ignored
        wr(A_LIMIT, 32'h10);
        rd("R6 locked limit", A_LIMIT, 32'hFFFF_FFFE);
        set_time(32'd5, 32'hFFFF_FFFD);
        two_ticks();
        rd("R5 wrap lo", A_TLO, 32'd0);
        rd("R5 wrap hi", A_THI, 32'd6);

        // R6 unlock and set all-ones limit
        wr(A_UNLK, 32'd1);
        wr(A_LIMIT, 32'hFFFF_FFFF);
        wr(A_UNLK, 32'd0);
        rd("R6 limit", A_LIMIT, 32'hFFFF_FFFF);
        set_time(32'd5, 32'hFFFF_FFFD);
        two_ticks();
        rd("R6 no early wrap lo", A_TLO, 32'hFFFF_FFFF);
        rd("R6 no early wrap hi", A_THI, 32'd5);
        two_ticks();
        rd("R6 wrap lo", A_TLO, 32'd1);
        rd("R6 wrap hi", A_THI, 32'd6);

        // R10 seconds flag every 4 ticks after a time write
        set_time(32'd0, 32'h10);
        wr(A_FLAGS, 32'h1E);
        two_ticks();
        rd_m("R10 no flag after 2 ticks", A_FLAGS, 32'h0, 32'h10);
        two_ticks();
        rd_m("R10 flag after 4 ticks", A_FLAGS, 32'h10, 32'h10);

        // R11 write 0 no effect, write 1 clears
        wr(A_FLAGS, 32'd0);
        rd_m("R11 zero write keeps flag", A_FLAGS, 32'h10, 32'h10);
        wr(A_FLAGS, 32'h10);
        rd_m("R11 one write clears", A_FLAGS, 32'h0, 32'h10);

        // R9 target compare
        wr(A_TGLO, 32'd100);
        wr(A_TGHI, 32'd0);
        wr(A_FLAGS, 32'h1E);
        rd_m("R9 below target", A_FLAGS, 32'h0, 32'h2);
        set_time(32'd0, 32'd100);
        rd_m("R9 equal target", A_FLAGS, 32'h2, 32'h2);
        set_time(32'd0, 32'd200);
        wr(A_FLAGS, 32'h2);
        rd_m("R11 set wins over clear", A_FLAGS, 32'h2, 32'h2);

        // R12 interrupt enables
        #1 chk("R12 not enabled", {31'd0, irq}, 32'd0);
        wr(A_CTRL, 32'h02);
        #1 chk("R12 enabled", {31'd0, irq}, 32'd1);
        wr(A_CTRL, 32'h04);
        #1 chk("R12 other enable", {31'd0, irq}, 32'd0);

        // R8 captures
        wr(A_TGHI, 32'hFFFF_FFFF);
        set_time(32'd7, 32'h1234);
        wr(A_FLAGS, 32'h1E);
        @(negedge clk); aux_in[0] = 1'b1;
        @(negedge clk);
        rd("R8 cap0 lo", A_C0LO, 32'h1234);
        rd("R8 cap0 hi", A_C0HI, 32'd7);
        rd_m("R8 cap0 flag", A_FLAGS, 32'h4, 32'hC);
        #1 chk("R12 capture irq", {31'd0, irq}, 32'd1);
        aux_in[0] = 1'b0;
        set_time(32'd7, 32'h2000);
        @(negedge clk); aux_in[0] = 1'b1;
        @(negedge clk); aux_in[1] = 1'b1;
        @(negedge clk);
        rd("R8 cap0 overwrite", A_C0LO, 32'h2000);
        rd("R8 cap1 lo", A_C1LO, 32'h2000);
        rd("R8 cap1 hi", A_C1HI, 32'd7);
        rd_m("R8 cap1 flag", A_FLAGS, 32'hC, 32'hC);
        aux_in = 2'b00;

        // R7 soft reset
        wr(A_RATE, 32'h1234_5678);
        wr(A_CTRL, 32'd1);
        wr(A_CTRL, 32'd0);
        rd("R7 rate", A_RATE, 32'hA000_0000);
        rd("R7 flags", A_FLAGS, 32'd0);
        rd("R7 capture", A_C0LO, 32'd0);
        rd("R7 limit", A_LIMIT, 32'hFFFF_FFFE);
        rd("R7 target", A_TGHI, 32'hFFFF_FFFF);
        #1 chk("R7 irq", {31'd0, irq}, 32'd0);

        repeat (3) @(negedge clk);
        chk("scoreboard drained", sb.size(), 32'd0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule